// File: doc/BRIEF.md
# Parallel-Port Register Bridge

This block sits on the peripheral side of an enhanced parallel port (IEEE 1284 EPP). It connects the host's byte-wide port to an internal register bus that has an 8-bit address and 16-bit data. All host strobes and port data pass through a two-flop synchronizer. The block then works only on clean, registered levels in its own clock domain, which runs at 10 MHz in the target system.

After reset the block stays passive until the host completes a 1284 negotiation. To start, the host presents the code 0x40 with the address strobe released and the data strobe asserted. The bridge answers on its status lines. The host then pulses the write line low and releases it, and the bridge marks the link as up. From then on, the bridge acknowledges every address strobe and data strobe by raising its wait line. It holds the wait line high until the host lets go of the strobe.

A register access takes three cycles on the port:
- one address write, which loads the address;
- a first data cycle, which carries the low byte;
- a second data cycle, which carries the high byte.

Writes are assembled and delivered as a single one-cycle write strobe. Reads fetch the whole word with one request and return it over two byte cycles.

Top module: `epp_reg_bridge`

## Requirements
- R1: During and after synchronous reset, the block holds these levels: wait low, data-out enable low, `stat_ack_n_o` high, `stat_pe_o` low, `stat_xsel_o` low, `stat_flt_n_o` low, and both register strobes low.
- R2: Before the link is up, the block answers negotiation only when the port data equals 0x40, the address strobe is released (high) and the data strobe is asserted (low). The answer drives `stat_pe_o`=1, `stat_ack_n_o`=0, `stat_flt_n_o`=1 and `stat_xsel_o`=1. Any other data value gets no answer.
- R3: After the answer, the host drives the write line low and then releases both the write line and the data strobe high. The block then completes negotiation by driving `stat_ack_n_o`=1 and `stat_pe_o`=0 while keeping `stat_xsel_o`=1. No strobe is acknowledged before this point.
- R4: Once the link is up, the wait output rises to acknowledge an asserted address or data strobe. It stays high for as long as the host keeps that strobe low, and it falls only after both strobes are seen released.
- R5: An address cycle with the write line low (write) loads the port byte into `reg_addr_o` and resets the byte position to the low byte. A half-finished word is therefore discarded.
- R6: A write data cycle carries the low byte first and the high byte second. `reg_wr_o` pulses for exactly one cycle, and only after the high byte, with the assembled word on `reg_wdata_o`.
- R7: A read data cycle (write line high) in the low-byte position issues exactly one single-cycle `reg_rd_o` pulse. The block samples `reg_rdata_i` RD_LATENCY cycles after the pulse and returns bits 7:0 in that cycle. The next read data cycle returns bits 15:8 without a new request.
- R8: The data-out enable is high only while a read data cycle is being acknowledged. It falls together with the wait output, and it stays low during write and address cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_n_i | input | 1 | Host direction line, low for write, high for read |
| host_astb_n_i | input | 1 | Host address strobe, active low |
| host_dstb_n_i | input | 1 | Host data strobe, active low |
| host_pd_i | input | 8 | Port data from the host |
| host_pd_o | output | 8 | Port data towards the host during reads |
| host_pd_oe_o | output | 1 | Enable for the port data driver |
| host_wait_o | output | 1 | Strobe acknowledge (wait) line |
| stat_ack_n_o | output | 1 | Negotiation acknowledge status, active low |
| stat_pe_o | output | 1 | Negotiation answer status line |
| stat_xsel_o | output | 1 | Mode-accepted select status line |
| stat_flt_n_o | output | 1 | Capability status line, active low |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 16 | Register write data |
| reg_wr_o | output | 1 | Register write strobe, one cycle |
| reg_rd_o | output | 1 | Register read request, one cycle |
| reg_rdata_i | input | 16 | Register read data, valid RD_LATENCY cycles after the request |

## Verification
The assertions check the following on every cycle:
- the wait line falls only when both host strobes were released at the point the synchronizer delivered them;
- the data driver is enabled only under an active acknowledge;
- each register strobe lasts one cycle, and a write never coincides with a read;
- no acknowledge appears before the negotiation status shows the link up.

The bench's directed scenarios are the only way to show the rest:
- the negotiation sequence and its refusal of a wrong code;
- the byte order of writes and reads;
- that a fresh address cycle throws away a half-written word;
- that the wait line really holds through a long strobe.

// File: rtl/epp_bridge_pkg.sv
package epp_bridge_pkg;

  typedef enum logic [1:0] {
    NEG_IDLE,
    NEG_ANSWER,
    NEG_STROBED,
    NEG_LINKED
  } neg_state_t;

  typedef enum logic [1:0] {
    CY_IDLE,
    CY_FETCH,
    CY_HOLD
  } cyc_state_t;

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/epp_negotiator.sv
module epp_negotiator
  import epp_bridge_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] NEG_CODE = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n_s,
  input  logic              astb_n_s,
  input  logic              dstb_n_s,
  input  logic [PORT_W-1:0] pd_s,
  output logic              link_up_o,
  output logic              ack_n_o,
  output logic              pe_o,
  output logic              xsel_o,
  output logic              flt_n_o
);

  neg_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= NEG_IDLE;
      link_up_o <= 1'b0;
      ack_n_o   <= 1'b1;
      pe_o      <= 1'b0;
      xsel_o    <= 1'b0;
      flt_n_o   <= 1'b0;
    end else begin
      case (state_q)
        NEG_IDLE: begin
          if ((pd_s == NEG_CODE) && astb_n_s && !dstb_n_s) begin
            state_q <= NEG_ANSWER;
            pe_o    <= 1'b1;
            ack_n_o <= 1'b0;
            flt_n_o <= 1'b1;
            xsel_o  <= 1'b1;
          end
        end
        NEG_ANSWER: begin
          if (!wr_n_s) state_q <= NEG_STROBED;
        end
        NEG_STROBED: begin
          if (wr_n_s && dstb_n_s) begin
            state_q   <= NEG_LINKED;
            ack_n_o   <= 1'b1;
            pe_o      <= 1'b0;
            link_up_o <= 1'b1;
          end
        end
        NEG_LINKED: state_q <= NEG_LINKED;
        default:    state_q <= NEG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
  import epp_bridge_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int DATA_W     = 16,
  parameter int RD_LATENCY = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_up_i,
  input  logic              wr_n_s,
  input  logic              astb_n_s,
  input  logic              dstb_n_s,
  input  logic [PORT_W-1:0] pd_s,
  output logic              busy_o,
  output logic              pd_oe_o,
  output logic [PORT_W-1:0] pd_o,
  output logic [PORT_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);

  localparam int LANES  = DATA_W / PORT_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CNT_W  = (RD_LATENCY > 0) ? $clog2(RD_LATENCY + 1) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
  localparam logic [CNT_W-1:0]  LAT_END   = CNT_W'(RD_LATENCY);

  cyc_state_t        state_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0]  wait_q;
  logic [DATA_W-1:0] wstage_q;
  logic [DATA_W-1:0] rbuf_q;
  logic [DATA_W-1:0] assembled;

  logic addr_hit, data_hit, all_free;
  assign addr_hit = !astb_n_s && dstb_n_s;
  assign data_hit = !dstb_n_s && astb_n_s;
  assign all_free = astb_n_s && dstb_n_s;

  // final word: earlier lanes from staging, last lane straight from the port
  always_comb begin
    assembled = wstage_q;
    assembled[LAST_LANE*PORT_W +: PORT_W] = pd_s;
  end

  function automatic logic [LANE_W-1:0] next_lane(input logic [LANE_W-1:0] l);
    return (l == LAST_LANE) ? '0 : LANE_W'(l + 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= CY_IDLE;
      lane_q      <= '0;
      wait_q      <= '0;
      wstage_q    <= '0;
      rbuf_q      <= '0;
      busy_o      <= 1'b0;
      pd_oe_o     <= 1'b0;
      pd_o        <= '0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
    end else begin
      reg_wr_o <= 1'b0;
      reg_rd_o <= 1'b0;
      case (state_q)
        CY_IDLE: begin
          if (link_up_i && addr_hit) begin
            busy_o  <= 1'b1;
            state_q <= CY_HOLD;
            if (!wr_n_s) begin
              reg_addr_o <= pd_s;
              lane_q     <= '0;
            end
          end else if (link_up_i && data_hit) begin
            if (!wr_n_s) begin
              busy_o  <= 1'b1;
              state_q <= CY_HOLD;
              if (lane_q == LAST_LANE) begin
                reg_wdata_o <= assembled;
                reg_wr_o    <= 1'b1;
              end else begin
                wstage_q[lane_q*PORT_W +: PORT_W] <= pd_s;
              end
              lane_q <= next_lane(lane_q);
            end else if (lane_q == '0) begin
              reg_rd_o <= 1'b1;
              wait_q   <= '0;
              state_q  <= CY_FETCH;
            end else begin
              pd_o    <= rbuf_q[lane_q*PORT_W +: PORT_W];
              pd_oe_o <= 1'b1;
              busy_o  <= 1'b1;
              lane_q  <= next_lane(lane_q);
              state_q <= CY_HOLD;
            end
          end
        end
        CY_FETCH: begin
          if (wait_q == LAT_END) begin
            rbuf_q  <= reg_rdata_i;
            pd_o    <= reg_rdata_i[PORT_W-1:0];
            pd_oe_o <= 1'b1;
            busy_o  <= 1'b1;
            lane_q  <= next_lane(lane_q);
            state_q <= CY_HOLD;
          end else begin
            wait_q <= CNT_W'(wait_q + 1'b1);
          end
        end
        CY_HOLD: begin
          if (all_free) begin
            busy_o  <= 1'b0;
            pd_oe_o <= 1'b0;
            state_q <= CY_IDLE;
          end
        end
        default: state_q <= CY_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/epp_reg_bridge.sv
module epp_reg_bridge #(
  parameter int PORT_W     = 8,
  parameter int DATA_W     = 16,
  parameter int RD_LATENCY = 1,
  parameter int SYNC_STAGES = 2,
  parameter logic [PORT_W-1:0] NEG_CODE = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_n_i,
  input  logic              host_astb_n_i,
  input  logic              host_dstb_n_i,
  input  logic [PORT_W-1:0] host_pd_i,
  output logic [PORT_W-1:0] host_pd_o,
  output logic              host_pd_oe_o,
  output logic              host_wait_o,
  output logic              stat_ack_n_o,
  output logic              stat_pe_o,
  output logic              stat_xsel_o,
  output logic              stat_flt_n_o,
  output logic [PORT_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);

  localparam int SW = 3 + PORT_W;
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {PORT_W{1'b0}}};

  logic [SW-1:0]     raw_bus, sync_bus;
  logic              wr_n_s, astb_n_s, dstb_n_s, link_up;
  logic [PORT_W-1:0] pd_s;

  assign raw_bus = {host_wr_n_i, host_astb_n_i, host_dstb_n_i, host_pd_i};
  assign {wr_n_s, astb_n_s, dstb_n_s, pd_s} = sync_bus;

  epp_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_bus),
    .q_o (sync_bus)
  );

  epp_negotiator #(.PORT_W(PORT_W), .NEG_CODE(NEG_CODE)) u_neg (
    .clk       (clk),
    .rst       (rst),
    .wr_n_s    (wr_n_s),
    .astb_n_s  (astb_n_s),
    .dstb_n_s  (dstb_n_s),
    .pd_s      (pd_s),
    .link_up_o (link_up),
    .ack_n_o   (stat_ack_n_o),
    .pe_o      (stat_pe_o),
    .xsel_o    (stat_xsel_o),
    .flt_n_o   (stat_flt_n_o)
  );

  epp_cycle_engine #(.PORT_W(PORT_W), .DATA_W(DATA_W), .RD_LATENCY(RD_LATENCY)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .link_up_i   (link_up),
    .wr_n_s      (wr_n_s),
    .astb_n_s    (astb_n_s),
    .dstb_n_s    (dstb_n_s),
    .pd_s        (pd_s),
    .busy_o      (host_wait_o),
    .pd_oe_o     (host_pd_oe_o),
    .pd_o        (host_pd_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_rdata_i (reg_rdata_i)
  );

endmodule

// File: rtl/epp_reg_bridge_chk.sv
module epp_reg_bridge_chk (
  input logic clk,
  input logic rst,
  input logic host_astb_n_i,
  input logic host_dstb_n_i,
  input logic host_pd_oe_o,
  input logic host_wait_o,
  input logic stat_ack_n_o,
  input logic stat_xsel_o,
  input logic reg_wr_o,
  input logic reg_rd_o
);

  // R4: the acknowledge drops only when both strobes reached the logic released
  a_r4_wait_release: assert property (@(posedge clk) disable iff (rst)
    $fell(host_wait_o) |-> ($past(host_astb_n_i, 3) && $past(host_dstb_n_i, 3)));

  // R8: the port driver is on only under an acknowledge
  a_r8_oe_under_wait: assert property (@(posedge clk) disable iff (rst)
    host_pd_oe_o |-> host_wait_o);

  // R8: driver and acknowledge are released together
  a_r8_oe_drops_with_wait: assert property (@(posedge clk) disable iff (rst)
    ($fell(host_wait_o) && $past(host_pd_oe_o)) |-> !host_pd_oe_o);

  // R6: write strobe is a single cycle
  a_r6_wr_single: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o);

  // R7: read request is a single cycle
  a_r7_rd_single: assert property (@(posedge clk) disable iff (rst)
    reg_rd_o |=> !reg_rd_o);

  // R6: write and read never coincide
  a_r6_wr_not_rd: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> !reg_rd_o);

  // R3: no acknowledge before the link-up status
  a_r3_no_ack_before_link: assert property (@(posedge clk) disable iff (rst)
    host_wait_o |-> (stat_xsel_o && stat_ack_n_o));

endmodule

bind epp_reg_bridge epp_reg_bridge_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .host_astb_n_i (host_astb_n_i),
  .host_dstb_n_i (host_dstb_n_i),
  .host_pd_oe_o  (host_pd_oe_o),
  .host_wait_o   (host_wait_o),
  .stat_ack_n_o  (stat_ack_n_o),
  .stat_xsel_o   (stat_xsel_o),
  .reg_wr_o      (reg_wr_o),
  .reg_rd_o      (reg_rd_o)
);

// File: tb/tb_epp_reg_bridge.sv
`timescale 1ns/1ps
module tb_epp_reg_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_n = 1'b0, astb_n = 1'b0, dstb_n = 1'b1;
  logic [7:0]  pd_in = 8'h00;
  logic [7:0]  pd_out;
  logic        pd_oe, wait_l, ack_n, pe, xsel, flt_n;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0]  last_a = '0;
  logic [15:0] last_d = '0;
  logic [15:0] model [256];
  logic        done = 1'b0;

  always #5 clk = ~clk;

  epp_reg_bridge dut (
    .clk(clk), .rst(rst),
    .host_wr_n_i(wr_n), .host_astb_n_i(astb_n), .host_dstb_n_i(dstb_n),
    .host_pd_i(pd_in), .host_pd_o(pd_out), .host_pd_oe_o(pd_oe),
    .host_wait_o(wait_l), .stat_ack_n_o(ack_n), .stat_pe_o(pe),
    .stat_xsel_o(xsel), .stat_flt_n_o(flt_n),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_wr_o(reg_wr),
    .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
  );

  // register file model with one cycle of read latency
  initial reg_rdata = '0;
  always @(posedge clk) begin
    if (!rst) begin
      if (reg_wr) begin
        wr_cnt <= wr_cnt + 1;
        last_a <= reg_addr;
        last_d <= reg_wdata;
        model[reg_addr] <= reg_wdata;
      end
      if (reg_rd) begin
        rd_cnt <= rd_cnt + 1;
        reg_rdata <= model[reg_addr];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_lvl(input logic lvl);
    int n = 0;
    while (wait_l !== lvl && n < 500) begin @(negedge clk); n++; end
    if (wait_l !== lvl) chk("R4 wait timeout", {31'b0, wait_l}, {31'b0, lvl});
  endtask

  task automatic host_addr(input logic [7:0] a);
    @(negedge clk); pd_in = a; wr_n = 1'b0; astb_n = 1'b0;
    wait_lvl(1'b1);
    chk("R8 no drive on address cycle", {31'b0, pd_oe}, 32'd0);
    astb_n = 1'b1;
    wait_lvl(1'b0);
  endtask

  task automatic host_wbyte(input logic [7:0] d);
    @(negedge clk); pd_in = d; wr_n = 1'b0; dstb_n = 1'b0;
    wait_lvl(1'b1);
    chk("R8 no drive on write cycle", {31'b0, pd_oe}, 32'd0);
    dstb_n = 1'b1;
    wait_lvl(1'b0);
  endtask

  task automatic host_rbyte(output logic [7:0] d);
    @(negedge clk); wr_n = 1'b1; dstb_n = 1'b0;
    wait_lvl(1'b1);
    chk("R8 drive during read ack", {31'b0, pd_oe}, 32'd1);
    d = pd_out;
    dstb_n = 1'b1;
    wait_lvl(1'b0);
    chk("R8 released with wait", {31'b0, pd_oe}, 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 wait", {31'b0, wait_l}, 32'd0);
    chk("R1 oe", {31'b0, pd_oe}, 32'd0);
    chk("R1 ack_n", {31'b0, ack_n}, 32'd1);
    chk("R1 pe", {31'b0, pe}, 32'd0);
    chk("R1 xsel", {31'b0, xsel}, 32'd0);
    chk("R1 flt_n", {31'b0, flt_n}, 32'd0);
    chk("R1 strobes", {30'b0, reg_wr, reg_rd}, 32'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_prelink;
    @(negedge clk); wr_n = 1'b1; astb_n = 1'b1; pd_in = 8'h41; dstb_n = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 wrong code no answer ack_n", {31'b0, ack_n}, 32'd1);
    chk("R2 wrong code no answer xsel", {31'b0, xsel}, 32'd0);
    wr_n = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3 no ack before link", {31'b0, wait_l}, 32'd0);
    chk("R3 no write before link", wr_cnt, 32'd0);
    dstb_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_negotiate;
    int n = 0;
    pd_in = 8'h40; astb_n = 1'b1; dstb_n = 1'b0;
    while (!(pe === 1'b1 && ack_n === 1'b0) && n < 100) begin @(negedge clk); n++; end
    chk("R2 answer pe", {31'b0, pe}, 32'd1);
    chk("R2 answer ack_n", {31'b0, ack_n}, 32'd0);
    chk("R2 answer flt_n", {31'b0, flt_n}, 32'd1);
    chk("R2 answer xsel", {31'b0, xsel}, 32'd1);
    wr_n = 1'b0;
    repeat (10) @(negedge clk);
    dstb_n = 1'b1; wr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 done ack_n", {31'b0, ack_n}, 32'd1);
    chk("R3 done xsel", {31'b0, xsel}, 32'd1);
    chk("R3 done pe", {31'b0, pe}, 32'd0);
  endtask

  task automatic t_write(input logic [7:0] a, input logic [15:0] d);
    int base = wr_cnt;
    host_addr(a);
    host_wbyte(d[7:0]);
    chk("R6 no write after low byte", wr_cnt, base);
    host_wbyte(d[15:8]);
    chk("R6 one write after high byte", wr_cnt, base + 1);
    chk("R5 address", {24'b0, last_a}, {24'b0, a});
    chk("R6 word low-first", {16'b0, last_d}, {16'b0, d});
  endtask

  task automatic t_read(input logic [7:0] a, input logic [15:0] exp);
    logic [7:0] lo, hi;
    int base = rd_cnt;
    host_addr(a);
    host_rbyte(lo);
    host_rbyte(hi);
    chk("R7 low byte", {24'b0, lo}, {24'b0, exp[7:0]});
    chk("R7 high byte", {24'b0, hi}, {24'b0, exp[15:8]});
    chk("R7 one request per word", rd_cnt, base + 1);
  endtask

  task automatic t_restart;
    int base = wr_cnt;
    host_addr(8'h55);
    host_wbyte(8'hAA);
    host_addr(8'h56);
    host_wbyte(8'h11);
    chk("R5 restart no write yet", wr_cnt, base);
    host_wbyte(8'h22);
    chk("R5 restart single write", wr_cnt, base + 1);
    chk("R5 restart address", {24'b0, last_a}, 32'h56);
    chk("R5 restart word", {16'b0, last_d}, 32'h2211);
  endtask

  task automatic t_long_hold;
    @(negedge clk); pd_in = 8'h77; wr_n = 1'b0; astb_n = 1'b0;
    wait_lvl(1'b1);
    repeat (30) @(negedge clk);
    chk("R4 wait held while strobe low", {31'b0, wait_l}, 32'd1);
    astb_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 wait falls after release", {31'b0, wait_l}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    t_reset;
    t_prelink;
    t_negotiate;
    t_write(8'h12, 16'hBEEF);
    t_write(8'h34, 16'h1357);
    t_read(8'h12, 16'hBEEF);
    t_read(8'h34, 16'h1357);
    t_restart;
    t_read(8'h56, 16'h2211);
    t_long_hold;
    t_read(8'h12, 16'hBEEF);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule